// File: doc/BRIEF.md
# Lockable Two-Way Write-Back Data Cache

This block is a write-back, write-allocate data cache that sits between a CPU load/store port and a word-wide memory bus. It is two-way set associative. With the default parameters it has 64 sets of 64-byte lines, which gives 8 KB. Each line keeps a physical tag and three state bits: valid, dirty and lock. A lock bit removes its line from replacement. Software can use a maintenance port to write a complete tag word into any set and way. This pins a line whose physical address has no backing memory, and the line then serves as private scratch storage inside the cache.

The maintenance port has two operations. The first is an index-addressed tag store, which takes a single cycle and makes no bus traffic. The second is a flush, which walks every line, writes back the lines that are valid and dirty, and invalidates all of them. On the memory side, a guard answers any access above the mapped window by itself. A write there is accepted and dropped, and a read returns zero. So data that is flushed out of a pinned scratch line is lost, while data that stays resident can still be read back.

Top module: `lockable_dcache`

## Requirements
- R1: A load or store to a resident line completes from the cache with no bus beat, and a load after a store to the same address returns the stored word. `cpu_done` pulses once per access, and the bus is idle in that cycle.
- R2: A miss fills the whole line as 16 sequential 32-bit read beats at rising word addresses, starting at the line base. Each beat is held stable until `mem_ready`. The load then returns the word that memory holds.
- R3: A store hit marks the line dirty. When a dirty line is chosen as victim, its 16 words are written to the bus before the fill begins.
- R4: The victim is chosen in this order: an unlocked invalid way (way 0 before way 1), otherwise the per-set least-recently-used unlocked way. A locked way is never chosen.
- R5: Tag store (`mnt_op`=0) takes its set from `mnt_addr[11:6]` and its way from `mnt_addr[0]`. The tag comes from word bits [31:12]. The state bits are: bit 6 dirty, bit 5 valid, bit 3 lock. The operation completes in one cycle with no bus beat.
- R6: A line pinned as locked and valid serves loads and stores as hits. The other way of that set keeps caching ordinary traffic, and the locked line is never evicted by it.
- R7: When both ways of the addressed set are locked and the access misses, it bypasses the cache as one bus beat. A load returns the bus data, and a store writes the bus directly.
- R8: Flush (`mnt_op`=1) writes back every valid dirty line, clears valid and dirty on all lines and keeps lock bits. Only write beats occur during a flush. Later loads refetch from memory.
- R9: An address with any bit set at or above `MAP_BITS` never appears on the memory bus. Writes to such an address are accepted silently, and reads from it return zero.
- R10: After reset, every line is invalid, `cpu_done`, `mnt_done` and `mem_valid` are low, and the first load misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU access request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address (word aligned) |
| cpu_wdata | input | 32 | Store data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load data, valid with `cpu_done` |
| mnt_req | input | 1 | Maintenance request, held until `mnt_done` |
| mnt_op | input | 1 | 0 = tag store, 1 = flush |
| mnt_addr | input | 32 | Index address: set in [11:6], way in [0] |
| mnt_tag_word | input | 32 | Tag word for tag store |
| mnt_done | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Bus beat request |
| mem_ready | input | 1 | Bus beat accepted |
| mem_we | output | 1 | Beat direction, 1 = write |
| mem_addr | output | 32 | Beat word address |
| mem_wdata | output | 32 | Write beat data |
| mem_rdata | input | 32 | Read beat data, valid with `mem_ready` |

## Verification
The bench keeps the default geometry of 64 sets, 64-byte lines and 32-bit words. This way the pinning loop runs over all 64 sets, and the tag word 0x70004028 lands exactly as software would write it. It sets `MAP_BITS` to 16, so only the lowest 64 KB reaches the bench memory. The scratch tag 0x70004, plus a few addresses just above 1 MB, then fall into the unmapped region. That puts the silent-write and zero-read path, and the data loss after a flush, within reach of short directed sequences. The bus model stalls one cycle in four, so the beat hold rule is exercised during fills, write-backs and bypasses.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

    // Bit positions inside a software tag word; the tag field is the top bits.
    localparam int TW_DIRTY_BIT = 6;
    localparam int TW_VALID_BIT = 5;
    localparam int TW_LOCK_BIT  = 3;

    typedef struct packed {
        logic lock;
        logic valid;
        logic dirty;
    } line_flags_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WB,
        ST_FILL,
        ST_BYP,
        ST_FLUSH
    } ctrl_state_t;

    typedef enum logic {
        MNT_SETTAG = 1'b0,
        MNT_FLUSH  = 1'b1
    } mnt_op_t;

    // Returns {bypass, way}: invalid unlocked first, else LRU among unlocked.
    function automatic logic [1:0] pick_victim(input line_flags_t f0,
                                               input line_flags_t f1,
                                               input logic lru);
        logic [1:0] r;
        if (f0.lock && f1.lock)  r = 2'b10;
        else if (f0.lock)        r = 2'b01;
        else if (f1.lock)        r = 2'b00;
        else if (!f0.valid)      r = 2'b00;
        else if (!f1.valid)      r = 2'b01;
        else                     r = {1'b0, lru};
        return r;
    endfunction

    function automatic line_flags_t flags_from_word(input logic [31:0] w);
        line_flags_t f;
        f.lock  = w[TW_LOCK_BIT];
        f.valid = w[TW_VALID_BIT];
        f.dirty = w[TW_DIRTY_BIT];
        return f;
    endfunction

endpackage

// File: rtl/dcache_tag_store.sv
module dcache_tag_store
    import dcache_pkg::*;
#(
    parameter int SETS  = 64,
    parameter int TAG_W = 20,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [SET_W-1:0]           rd_set,
    output logic [1:0][TAG_W-1:0]      rd_tag,
    output line_flags_t [1:0]          rd_flg,
    output logic                       rd_lru,
    input  logic                       wr_en,
    input  logic [SET_W-1:0]           wr_set,
    input  logic                       wr_way,
    input  logic [TAG_W-1:0]           wr_tag,
    input  line_flags_t                wr_flg,
    input  logic                       lru_en,
    input  logic [SET_W-1:0]           lru_set,
    input  logic                       lru_val
);

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [TAG_W-1:0] tag_q [SETS];
        line_flags_t      flg_q [SETS];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < SETS; s++) begin
                    tag_q[s] <= '0;
                    flg_q[s] <= '0;
                end
            end else if (wr_en && wr_way == 1'(w)) begin
                tag_q[wr_set] <= wr_tag;
                flg_q[wr_set] <= wr_flg;
            end
        end

        assign rd_tag[w] = tag_q[rd_set];
        assign rd_flg[w] = flg_q[rd_set];
    end

    logic [SETS-1:0] lru_q;

    always_ff @(posedge clk) begin
        if (rst)         lru_q <= '0;
        else if (lru_en) lru_q[lru_set] <= lru_val;
    end

    assign rd_lru = lru_q[rd_set];

endmodule

// File: rtl/dcache_data_store.sv
module dcache_data_store #(
    parameter int SETS  = 64,
    parameter int WORDS = 16,
    parameter int DW    = 32,
    localparam int IDX_W = $clog2(SETS * WORDS)
) (
    input  logic             clk,
    input  logic             rd_way,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rdata,
    input  logic             wr_en,
    input  logic             wr_way,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wdata
);

    logic [1:0][DW-1:0] way_rd;

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [DW-1:0] ram [SETS*WORDS];

        always_ff @(posedge clk) begin
            if (wr_en && wr_way == 1'(w))
                ram[wr_idx] <= wdata;
        end

        assign way_rd[w] = ram[rd_idx];
    end

    assign rdata = way_rd[rd_way];

endmodule

// File: rtl/dcache_unmapped_guard.sv
module dcache_unmapped_guard #(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int MAP_BITS = 28
) (
    input  logic          c_valid,
    input  logic          c_we,
    input  logic [AW-1:0] c_addr,
    input  logic [DW-1:0] c_wdata,
    output logic          c_ready,
    output logic [DW-1:0] c_rdata,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata
);

    logic mapped;
    assign mapped = (c_addr[AW-1:MAP_BITS] == '0);

    assign mem_valid = c_valid && mapped;
    assign mem_we    = c_we;
    assign mem_addr  = c_addr;
    assign mem_wdata = c_wdata;

    // Unmapped beats are absorbed at once: writes vanish, reads give zero.
    assign c_ready = mapped ? mem_ready : c_valid;
    assign c_rdata = mapped ? mem_rdata : '0;

endmodule

// File: rtl/lockable_dcache.sv
module lockable_dcache
    import dcache_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int SETS       = 64,
    parameter int LINE_BYTES = 64,
    parameter int MAP_BITS   = 28
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_done,
    output logic [DW-1:0] cpu_rdata,
    input  logic          mnt_req,
    input  logic          mnt_op,
    input  logic [AW-1:0] mnt_addr,
    input  logic [AW-1:0] mnt_tag_word,
    output logic          mnt_done,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = AW - SET_W - OFF_W;
    localparam int WORDS  = LINE_BYTES / (DW / 8);
    localparam int BEAT_W = $clog2(WORDS);
    localparam int BYTE_W = $clog2(DW / 8);
    localparam int IDX_W  = SET_W + BEAT_W;
    localparam int FL_W   = SET_W + 1;

    ctrl_state_t state;
    logic [BEAT_W-1:0] beat;
    logic              op_way;
    logic [SET_W-1:0]  op_set;
    logic [TAG_W-1:0]  wb_tag;
    logic              op_lock;
    logic              wb_flush;
    logic [FL_W-1:0]   fl_idx;

    // CPU address fields
    logic [TAG_W-1:0]  c_tag;
    logic [SET_W-1:0]  c_set;
    logic [BEAT_W-1:0] c_word;
    assign c_tag  = cpu_addr[AW-1 -: TAG_W];
    assign c_set  = cpu_addr[OFF_W +: SET_W];
    assign c_word = cpu_addr[BYTE_W +: BEAT_W];

    logic              fl_way;
    logic [SET_W-1:0]  fl_set;
    assign fl_way = fl_idx[0];
    assign fl_set = fl_idx[FL_W-1:1];

    // Tag store
    logic [SET_W-1:0]     t_rd_set;
    logic [1:0][TAG_W-1:0] t_tag;
    line_flags_t [1:0]    t_flg;
    logic                 t_lru;
    logic                 tw_en, tw_way, lru_en, lru_val;
    logic [SET_W-1:0]     tw_set;
    logic [TAG_W-1:0]     tw_tag;
    line_flags_t          tw_flg;

    assign t_rd_set = (state == ST_FLUSH) ? fl_set : c_set;

    dcache_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst(rst),
        .rd_set(t_rd_set), .rd_tag(t_tag), .rd_flg(t_flg), .rd_lru(t_lru),
        .wr_en(tw_en), .wr_set(tw_set), .wr_way(tw_way),
        .wr_tag(tw_tag), .wr_flg(tw_flg),
        .lru_en(lru_en), .lru_set(c_set), .lru_val(lru_val)
    );

    // Data store
    logic              d_rd_way, dw_en, dw_way;
    logic [IDX_W-1:0]  d_rd_idx, dw_idx;
    logic [DW-1:0]     d_rdata, dw_data;

    dcache_data_store #(.SETS(SETS), .WORDS(WORDS), .DW(DW)) u_data (
        .clk(clk),
        .rd_way(d_rd_way), .rd_idx(d_rd_idx), .rdata(d_rdata),
        .wr_en(dw_en), .wr_way(dw_way), .wr_idx(dw_idx), .wdata(dw_data)
    );

    // Bus side through the unmapped guard
    logic          g_valid, g_we, g_ready;
    logic [AW-1:0] g_addr;
    logic [DW-1:0] g_wdata, g_rdata;

    dcache_unmapped_guard #(.AW(AW), .DW(DW), .MAP_BITS(MAP_BITS)) u_guard (
        .c_valid(g_valid), .c_we(g_we), .c_addr(g_addr), .c_wdata(g_wdata),
        .c_ready(g_ready), .c_rdata(g_rdata),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    // Lookup
    logic hit0, hit1, hit, hit_way, last_beat;
    logic [1:0] victim;
    line_flags_t vic_flg;
    assign hit0      = t_flg[0].valid && (t_tag[0] == c_tag);
    assign hit1      = t_flg[1].valid && (t_tag[1] == c_tag);
    assign hit       = hit0 || hit1;
    assign hit_way   = !hit0;
    assign victim    = pick_victim(t_flg[0], t_flg[1], t_lru);
    assign vic_flg   = t_flg[victim[0]];
    assign last_beat = (beat == BEAT_W'(WORDS - 1));

    assign d_rd_way = (state == ST_WB) ? op_way : hit_way;
    assign d_rd_idx = (state == ST_WB) ? {op_set, beat} : {c_set, c_word};

    logic flush_busy;
    assign flush_busy = (state == ST_FLUSH) || (state == ST_WB && wb_flush);

    always_comb begin
        g_valid = 1'b0;
        g_we    = 1'b0;
        g_addr  = cpu_addr;
        g_wdata = cpu_wdata;
        unique case (state)
            ST_WB: begin
                g_valid = 1'b1;
                g_we    = 1'b1;
                g_addr  = {wb_tag, op_set, beat, {BYTE_W{1'b0}}};
                g_wdata = d_rdata;
            end
            ST_FILL: begin
                g_valid = 1'b1;
                g_addr  = {c_tag, c_set, beat, {BYTE_W{1'b0}}};
            end
            ST_BYP: begin
                g_valid = 1'b1;
                g_we    = cpu_we;
            end
            default: ;
        endcase
    end

    // Array write controls
    always_comb begin
        tw_en   = 1'b0;
        tw_set  = c_set;
        tw_way  = hit_way;
        tw_tag  = c_tag;
        tw_flg  = '0;
        lru_en  = 1'b0;
        lru_val = !hit_way;
        dw_en   = 1'b0;
        dw_way  = hit_way;
        dw_idx  = {c_set, c_word};
        dw_data = cpu_wdata;
        unique case (state)
            ST_IDLE: begin
                if (mnt_req) begin
                    if (mnt_op == MNT_SETTAG) begin
                        tw_en  = 1'b1;
                        tw_set = mnt_addr[OFF_W +: SET_W];
                        tw_way = mnt_addr[0];
                        tw_tag = mnt_tag_word[AW-1 -: TAG_W];
                        tw_flg = flags_from_word(mnt_tag_word);
                    end
                end else if (cpu_req && hit) begin
                    lru_en = 1'b1;
                    if (cpu_we) begin
                        dw_en  = 1'b1;
                        tw_en  = 1'b1;
                        tw_flg = '{lock: t_flg[hit_way].lock, valid: 1'b1, dirty: 1'b1};
                    end
                end
            end
            ST_WB: begin
                if (g_ready && last_beat) begin
                    tw_en  = 1'b1;
                    tw_set = op_set;
                    tw_way = op_way;
                    tw_tag = wb_tag;
                    tw_flg = '{lock: op_lock, valid: 1'b0, dirty: 1'b0};
                end
            end
            ST_FILL: begin
                if (g_ready) begin
                    dw_en   = 1'b1;
                    dw_way  = op_way;
                    dw_idx  = {c_set, beat};
                    dw_data = g_rdata;
                    if (last_beat) begin
                        tw_en  = 1'b1;
                        tw_way = op_way;
                        tw_flg = '{lock: 1'b0, valid: 1'b1, dirty: 1'b0};
                    end
                end
            end
            ST_FLUSH: begin
                if (!(t_flg[fl_way].valid && t_flg[fl_way].dirty)) begin
                    tw_en  = 1'b1;
                    tw_set = fl_set;
                    tw_way = fl_way;
                    tw_tag = t_tag[fl_way];
                    tw_flg = '{lock: t_flg[fl_way].lock, valid: 1'b0, dirty: 1'b0};
                end
            end
            default: ;
        endcase
    end

    // Control sequence
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            beat      <= '0;
            op_way    <= 1'b0;
            op_set    <= '0;
            wb_tag    <= '0;
            op_lock   <= 1'b0;
            wb_flush  <= 1'b0;
            fl_idx    <= '0;
            cpu_done  <= 1'b0;
            cpu_rdata <= '0;
            mnt_done  <= 1'b0;
        end else begin
            cpu_done <= 1'b0;
            mnt_done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (mnt_req) begin
                        if (mnt_op == MNT_SETTAG) begin
                            mnt_done <= 1'b1;
                        end else begin
                            fl_idx <= '0;
                            state  <= ST_FLUSH;
                        end
                    end else if (cpu_req) begin
                        if (hit) begin
                            cpu_done <= 1'b1;
                            if (!cpu_we) cpu_rdata <= d_rdata;
                        end else if (victim[1]) begin
                            state <= ST_BYP;
                        end else begin
                            op_way   <= victim[0];
                            op_set   <= c_set;
                            wb_tag   <= t_tag[victim[0]];
                            op_lock  <= vic_flg.lock;
                            wb_flush <= 1'b0;
                            beat     <= '0;
                            state    <= (vic_flg.valid && vic_flg.dirty) ? ST_WB : ST_FILL;
                        end
                    end
                end
                ST_WB: begin
                    if (g_ready) begin
                        beat <= beat + 1'b1;
                        if (last_beat) begin
                            beat  <= '0;
                            state <= wb_flush ? ST_FLUSH : ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    if (g_ready) begin
                        beat <= beat + 1'b1;
                        if (last_beat) begin
                            beat  <= '0;
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_BYP: begin
                    if (g_ready) begin
                        cpu_done <= 1'b1;
                        if (!cpu_we) cpu_rdata <= g_rdata;
                        state <= ST_IDLE;
                    end
                end
                ST_FLUSH: begin
                    if (t_flg[fl_way].valid && t_flg[fl_way].dirty) begin
                        op_way   <= fl_way;
                        op_set   <= fl_set;
                        wb_tag   <= t_tag[fl_way];
                        op_lock  <= t_flg[fl_way].lock;
                        wb_flush <= 1'b1;
                        beat     <= '0;
                        state    <= ST_WB;
                    end else if (fl_idx == {FL_W{1'b1}}) begin
                        wb_flush <= 1'b0;
                        mnt_done <= 1'b1;
                        state    <= ST_IDLE;
                    end else begin
                        fl_idx <= fl_idx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dcache_chk.sv
module dcache_chk #(
    parameter int AW       = 32,
    parameter int MAP_BITS = 28
) (
    input logic          clk,
    input logic          rst,
    input logic          cpu_done,
    input logic          mnt_done,
    input logic          mnt_op,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          flush_busy
);

    // R1
    done_bus_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_done |-> !mem_valid);

    // R2
    beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

    // R5
    settag_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mnt_done && !$past(mnt_op)) |-> !$past(mem_valid));

    // R8
    flush_write_only_chk: assert property (@(posedge clk) disable iff (rst)
        (flush_busy && mem_valid) |-> mem_we);

    // R9
    unmapped_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> ((mem_addr >> MAP_BITS) == '0));

endmodule

bind lockable_dcache dcache_chk #(.AW(AW), .MAP_BITS(MAP_BITS)) u_chk (
    .clk(clk), .rst(rst), .cpu_done(cpu_done), .mnt_done(mnt_done),
    .mnt_op(mnt_op), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .flush_busy(flush_busy)
);

// File: tb/sim_lockable_dcache.sv
`timescale 1ns/1ps
module sim_lockable_dcache;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_done;
    logic [31:0] cpu_rdata;
    logic        mnt_req = 1'b0, mnt_op = 1'b0;
    logic [31:0] mnt_addr = '0, mnt_tag_word = '0;
    logic        mnt_done;
    logic        mem_valid, mem_ready, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    always #4 clk = ~clk;

    lockable_dcache #(.MAP_BITS(16)) u0 (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .mnt_req(mnt_req), .mnt_op(mnt_op), .mnt_addr(mnt_addr),
        .mnt_tag_word(mnt_tag_word), .mnt_done(mnt_done),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Bus memory model: 64 KB, stalls one cycle in four
    logic [31:0] bmem [0:16383];
    logic [1:0]  tick = 2'd0;
    int          rd_count = 0, wr_count = 0;
    logic [31:0] rd_log [0:15];

    always @(posedge clk) tick <= tick + 2'd1;
    assign mem_ready = (tick != 2'd1);
    assign mem_rdata = bmem[mem_addr[15:2]];

    always @(posedge clk) begin
        if (!rst && mem_valid && mem_ready) begin
            if (mem_we) begin
                bmem[mem_addr[15:2]] <= mem_wdata;
                wr_count++;
            end else begin
                rd_log[rd_count[3:0]] <= mem_addr;
                rd_count++;
            end
        end
    end

    int  n_tests = 0, n_fail = 0;
    bit  finished = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_op(input logic we, input logic [31:0] a, input logic [31:0] wd,
                          output logic [31:0] rd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        forever begin
            @(posedge clk); #1;
            if (cpu_done) break;
        end
        rd = cpu_rdata;
        cpu_req = 1'b0;
    endtask

    task automatic mnt(input logic op, input logic [31:0] a, input logic [31:0] w);
        @(negedge clk);
        mnt_req = 1'b1; mnt_op = op; mnt_addr = a; mnt_tag_word = w;
        forever begin
            @(posedge clk); #1;
            if (mnt_done) break;
        end
        mnt_req = 1'b0;
    endtask

    // R10, R2: reset state and first line fill
    task automatic t_reset_fill();
        logic [31:0] d;
        int r0;
        @(negedge clk);
        check(!cpu_done && !mnt_done && !mem_valid, "R10 idle after reset",
              {29'd0, cpu_done, mnt_done, mem_valid}, 32'd0);
        r0 = rd_count;
        cpu_op(1'b0, 32'h0000_0100, '0, d);
        check(rd_count - r0 == 16, "R10 first load misses", rd_count - r0, 16);
        check(d == 32'h1000_0040, "R2 fill returns memory word", d, 32'h1000_0040);
        for (int i = 0; i < 16; i++)
            check(rd_log[i] == 32'h100 + 4 * i, "R2 beat address order", rd_log[i], 32'h100 + 4 * i);
    endtask

    // R1: hits stay in the cache
    task automatic t_hit();
        logic [31:0] d;
        int r0, w0;
        r0 = rd_count; w0 = wr_count;
        cpu_op(1'b1, 32'h0000_0104, 32'h0000_A5A5, d);
        cpu_op(1'b0, 32'h0000_0104, '0, d);
        check(d == 32'h0000_A5A5, "R1 load after store hit", d, 32'h0000_A5A5);
        check(rd_count == r0 && wr_count == w0, "R1 no bus beat on hit",
              rd_count + wr_count, r0 + w0);
    endtask

    // R3, R4: invalid way first, then LRU with dirty write-back
    task automatic t_evict();
        logic [31:0] d;
        int r0, w0;
        w0 = wr_count;
        cpu_op(1'b0, 32'h0000_1100, '0, d);
        check(wr_count == w0, "R4 invalid way used before eviction", wr_count - w0, 0);
        cpu_op(1'b0, 32'h0000_2100, '0, d);
        check(wr_count - w0 == 16, "R3 dirty victim written back", wr_count - w0, 16);
        check(bmem[32'h104 >> 2] == 32'h0000_A5A5, "R3 write-back data", bmem[32'h104 >> 2],
              32'h0000_A5A5);
        check(d == 32'h1000_0840, "R3 fill after write-back", d, 32'h1000_0840);
        r0 = rd_count;
        cpu_op(1'b0, 32'h0000_1100, '0, d);
        check(rd_count == r0 && d == 32'h1000_0440, "R4 recently used way kept", d, 32'h1000_0440);
    endtask

    // R5, R6: pin way 0 of every set as scratch storage
    task automatic t_lock();
        logic [31:0] d;
        int r0, w0;
        bit ok;
        r0 = rd_count; w0 = wr_count;
        for (int i = 0; i < 64; i++) mnt(1'b0, i << 6, 32'h7000_4028);
        check(rd_count == r0 && wr_count == w0, "R5 tag store without bus",
              rd_count + wr_count, r0 + w0);
        for (int k = 0; k < 10; k++) cpu_op(1'b1, 32'h7000_4000 + 4 * k, 10 - k, d);
        ok = 1'b1;
        for (int k = 0; k < 10; k++) begin
            cpu_op(1'b0, 32'h7000_4000 + 4 * k, '0, d);
            if (d != 32'(10 - k)) ok = 1'b0;
        end
        check(ok, "R6 scratch lines return stored data", {31'd0, ok}, 32'd1);
        check(rd_count == r0 && wr_count == w0, "R5 pinned line hits", rd_count, r0);
        cpu_op(1'b0, 32'h0000_0000, '0, d);
        check(d == 32'h1000_0000 && rd_count - r0 == 16, "R6 other way still caches", d,
              32'h1000_0000);
        cpu_op(1'b0, 32'h0000_1000, '0, d);
        check(d == 32'h1000_0400 && wr_count == w0, "R6 replacement spares locked way", d,
              32'h1000_0400);
        cpu_op(1'b0, 32'h7000_4000, '0, d);
        check(d == 32'd10, "R6 locked data survives conflicts", d, 32'd10);
    endtask

    // R7: both ways locked forces a single-beat bypass
    task automatic t_bypass();
        logic [31:0] d;
        int r0, w0;
        mnt(1'b0, 32'h0000_0141, 32'h0000_3028);
        r0 = rd_count; w0 = wr_count;
        cpu_op(1'b0, 32'h0000_0140, '0, d);
        check(rd_count - r0 == 1 && d == 32'h1000_0050, "R7 bypass load", d, 32'h1000_0050);
        cpu_op(1'b1, 32'h0000_0144, 32'h0000_BEEF, d);
        check(wr_count - w0 == 1, "R7 bypass store one beat", wr_count - w0, 1);
        check(bmem[32'h144 >> 2] == 32'h0000_BEEF, "R7 bypass store data",
              bmem[32'h144 >> 2], 32'h0000_BEEF);
    endtask

    // R8, R9: flush writes back mapped dirt, loses unmapped scratch data
    task automatic t_flush();
        logic [31:0] d;
        int r0, w0;
        cpu_op(1'b1, 32'h0000_1004, 32'h0000_5555, d);
        r0 = rd_count; w0 = wr_count;
        mnt(1'b1, '0, '0);
        check(wr_count - w0 == 16 && rd_count == r0, "R8 only dirty mapped line written",
              wr_count - w0, 16);
        check(bmem[32'h1004 >> 2] == 32'h0000_5555, "R8 flushed data in memory",
              bmem[32'h1004 >> 2], 32'h0000_5555);
        cpu_op(1'b0, 32'h7000_4000, '0, d);
        check(d == 32'd0 && rd_count == r0, "R9 scratch data lost after flush", d, 32'd0);
        cpu_op(1'b0, 32'h0000_1004, '0, d);
        check(d == 32'h0000_5555 && rd_count - r0 == 16, "R8 refetch after flush", d,
              32'h0000_5555);
    endtask

    // R9: unmapped traffic never reaches the bus
    task automatic t_unmapped();
        logic [31:0] d;
        int r0, w0;
        r0 = rd_count; w0 = wr_count;
        cpu_op(1'b1, 32'h0010_0040, 32'h0000_7777, d);
        cpu_op(1'b0, 32'h0010_0040, '0, d);
        check(d == 32'h0000_7777, "R9 resident unmapped data readable", d, 32'h0000_7777);
        cpu_op(1'b0, 32'h0020_0040, '0, d);
        check(d == 32'd0, "R9 unmapped read is zero", d, 32'd0);
        cpu_op(1'b0, 32'h0010_0040, '0, d);
        check(d == 32'd0, "R9 unmapped write dropped", d, 32'd0);
        check(rd_count == r0 && wr_count == w0, "R9 bus untouched",
              rd_count + wr_count, r0 + w0);
    endtask

    initial begin
        for (int i = 0; i < 16384; i++) bmem[i] = 32'h1000_0000 + i;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset_fill();
        t_hit();
        t_evict();
        t_lock();
        t_bypass();
        t_flush();
        t_unmapped();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule